// File: doc/BRIEF.md
# Synchronous FIFO Port Access Controller

This block is the access logic for one port of a clocked FIFO. On every rising edge of the port clock it decides whether a transfer happens, which way it goes (write into the device or read out of it), and whether the target is the FIFO array or the mailbox register. It turns that decision into single-cycle strobes for the FIFO core and the mailbox. It also produces the output-enable for the bidirectional data pad and the select for the read-data multiplexer.

A registered input-ready flag tells the writer whether the FIFO can take data. The flag is held low while reset is asserted and for the first edge after reset is released, and it falls whenever the core reports full. The FIFO storage, the mailbox register and the tri-state pad sit outside this block and consume its outputs.

Top module: `fifo_port_ctrl`

## Requirements
- R1: A strobe (fifo_wr_o, fifo_rd_o, mbox_wr_o, mbox_rd_o) is asserted only while cs_ni is 0 and en_i is 1; with cs_ni high or en_i low, all four are 0.
- R2: bus_oe_o is 1 exactly when cs_ni is 0 and wr_dir_i is 0; whenever cs_ni is 1, bus_oe_o is 0, so the pad is high impedance.
- R3: fifo_wr_o is asserted only while in_ready_o is 1 and fifo_full_i is 0.
- R4: in_ready_o is 0 while rst_ni is 0 and after the first rising edge that follows the release of reset. It may first be 1 after the second rising edge.
- R5: in_ready_o is a register on clk_i. After any rising edge that samples fifo_full_i = 1 it is 0. After the second and later edges that sample fifo_full_i = 0 it is 1.
- R6: With mbox_sel_i = 1, an enabled access drives only the mailbox strobe for its direction. With mbox_sel_i = 0, it drives only the FIFO strobe. At most one strobe is high in any cycle.
- R7: rdata_sel_o equals mbox_sel_i: 1 selects mailbox data and 0 selects FIFO output-register data.
- R8: fifo_rd_o is asserted only while fifo_empty_i is 0.
- R9: wr_dir_i = 1 makes an enabled access a write (fifo_wr_o or mbox_wr_o). wr_dir_i = 0 makes it a read (fifo_rd_o or mbox_rd_o).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock; transfers happen on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| en_i | input | 1 | Transfer enable |
| mbox_sel_i | input | 1 | 1 targets the mailbox, 0 targets the FIFO |
| wr_dir_i | input | 1 | 1 write, 0 read |
| fifo_full_i | input | 1 | FIFO core full status |
| fifo_empty_i | input | 1 | FIFO core empty status |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_rd_o | output | 1 | FIFO read strobe |
| mbox_wr_o | output | 1 | Mailbox write strobe |
| mbox_rd_o | output | 1 | Mailbox read strobe |
| bus_oe_o | output | 1 | Data pad output enable |
| rdata_sel_o | output | 1 | Read mux select, 1 = mailbox |
| in_ready_o | output | 1 | Registered input-ready flag |

## Verification
Assertions check these properties on every cycle:
- no strobe is raised without an enabled selection;
- the pad is never enabled while deselected;
- at most one strobe is active;
- no FIFO write occurs while the flag is low or the core is full;
- no FIFO read occurs while the core is empty;
- input-ready falls on the edge after full is seen.

Only the bench scenarios can show that input-ready rises on exactly the second edge after reset, and not later, and that it recovers once full clears. The bench also confirms that the direction input picks the correct strobe across random mixes of select, enable and status.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic {
    TGT_FIFO = 1'b0,
    TGT_MBOX = 1'b1
  } xfer_tgt_e;

  typedef struct packed {
    logic fifo_wr;
    logic fifo_rd;
    logic mbox_wr;
    logic mbox_rd;
  } strobe_t;
endpackage

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cs_ni,
  input  logic    en_i,
  input  logic    mbox_sel_i,
  input  logic    wr_dir_i,
  input  logic    fifo_full_i,
  input  logic    fifo_empty_i,
  input  logic    ready_i,
  output strobe_t stb_o,
  output logic    bus_oe_o,
  output logic    rdata_sel_o
);
  xfer_tgt_e tgt;
  logic      access;

  always_comb begin
    access      = ~cs_ni & en_i;
    tgt         = mbox_sel_i ? TGT_MBOX : TGT_FIFO;
    stb_o       = '0;
    if (access) begin
      unique case (tgt)
        TGT_FIFO: begin
          stb_o.fifo_wr = wr_dir_i & ready_i & ~fifo_full_i;
          stb_o.fifo_rd = ~wr_dir_i & ~fifo_empty_i;
        end
        TGT_MBOX: begin
          stb_o.mbox_wr = wr_dir_i;
          stb_o.mbox_rd = ~wr_dir_i;
        end
        default: stb_o = '0;
      endcase
    end
    bus_oe_o    = ~cs_ni & ~wr_dir_i;
    rdata_sel_o = (tgt == TGT_MBOX);
  end

  a_r1_no_stb_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || !en_i) |-> (stb_o == '0));
  a_r2_hiz_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !bus_oe_o);
  a_r3_wr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o.fifo_wr |-> (ready_i && !fifo_full_i));
  a_r6_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_o));
  a_r8_no_rd_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_empty_i |-> !stb_o.fifo_rd);
endmodule

// File: rtl/fpc_ready.sv
module fpc_ready #(
  parameter int unsigned READY_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fifo_full_i,
  output logic ready_o
);
  localparam int unsigned CW  = (READY_EDGES < 2) ? 1 : $clog2(READY_EDGES);
  localparam logic [CW-1:0] LIM = CW'(READY_EDGES - 1);

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      ready_q <= (cnt_q == LIM) & ~fifo_full_i;
    end
  end

  assign ready_o = ready_q;

  a_r5_full_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |=> !ready_o);
  a_r4_no_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cnt_q == LIM));
endmodule

// File: rtl/fifo_port_ctrl.sv
module fifo_port_ctrl
  import fpc_pkg::*;
#(
  parameter int unsigned READY_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic en_i,
  input  logic mbox_sel_i,
  input  logic wr_dir_i,
  input  logic fifo_full_i,
  input  logic fifo_empty_i,
  output logic fifo_wr_o,
  output logic fifo_rd_o,
  output logic mbox_wr_o,
  output logic mbox_rd_o,
  output logic bus_oe_o,
  output logic rdata_sel_o,
  output logic in_ready_o
);
  strobe_t stb;
  logic    ready;

  fpc_ready #(.READY_EDGES(READY_EDGES)) u_ready (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_full_i (fifo_full_i),
    .ready_o     (ready)
  );

  fpc_decode u_decode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_ni        (cs_ni),
    .en_i         (en_i),
    .mbox_sel_i   (mbox_sel_i),
    .wr_dir_i     (wr_dir_i),
    .fifo_full_i  (fifo_full_i),
    .fifo_empty_i (fifo_empty_i),
    .ready_i      (ready),
    .stb_o        (stb),
    .bus_oe_o     (bus_oe_o),
    .rdata_sel_o  (rdata_sel_o)
  );

  assign fifo_wr_o  = stb.fifo_wr;
  assign fifo_rd_o  = stb.fifo_rd;
  assign mbox_wr_o  = stb.mbox_wr;
  assign mbox_rd_o  = stb.mbox_rd;
  assign in_ready_o = ready;

  a_r9_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbox_wr_o || fifo_wr_o) |-> wr_dir_i);
endmodule

// File: tb/fifo_port_ctrl_tb.sv
module fifo_port_ctrl_tb;
  logic clk = 0, rst_ni = 0;
  logic cs_ni = 1, en_i = 0, mbox_sel_i = 0, wr_dir_i = 0;
  logic fifo_full_i = 0, fifo_empty_i = 1;
  logic fifo_wr_o, fifo_rd_o, mbox_wr_o, mbox_rd_o, bus_oe_o, rdata_sel_o, in_ready_o;
  int n_run = 0, n_fail = 0, edges = 0;
  logic mdl_rdy = 0;

  always #5 clk = ~clk;

  fifo_port_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .en_i(en_i),
    .mbox_sel_i(mbox_sel_i), .wr_dir_i(wr_dir_i), .fifo_full_i(fifo_full_i),
    .fifo_empty_i(fifo_empty_i), .fifo_wr_o(fifo_wr_o), .fifo_rd_o(fifo_rd_o),
    .mbox_wr_o(mbox_wr_o), .mbox_rd_o(mbox_rd_o), .bus_oe_o(bus_oe_o),
    .rdata_sel_o(rdata_sel_o), .in_ready_o(in_ready_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // expected strobes {fifo_wr, fifo_rd, mbox_wr, mbox_rd}
  function automatic logic [3:0] exp_stb(logic cs, logic en, logic mb, logic wr,
                                         logic full, logic empty, logic rdy);
    logic acc = !cs && en;
    exp_stb = {acc && !mb && wr && rdy && !full,
               acc && !mb && !wr && !empty,
               acc && mb && wr,
               acc && mb && !wr};
  endfunction

  task automatic check_comb();
    logic [3:0] e;
    e = exp_stb(cs_ni, en_i, mbox_sel_i, wr_dir_i, fifo_full_i, fifo_empty_i, mdl_rdy);
    #1;
    chk("R3 fifo_wr", fifo_wr_o, e[3]);
    chk("R8 fifo_rd", fifo_rd_o, e[2]);
    chk("R6 mbox_wr", mbox_wr_o, e[1]);
    chk("R9 mbox_rd", mbox_rd_o, e[0]);
    chk("R2 bus_oe", bus_oe_o, !cs_ni && !wr_dir_i);
    chk("R7 rdata_sel", rdata_sel_o, mbox_sel_i);
    if (cs_ni || !en_i) chk("R1 idle", |{fifo_wr_o, fifo_rd_o, mbox_wr_o, mbox_rd_o}, 1'b0);
  endtask

  // combinational checks, then one clock edge, then ready check
  task automatic step();
    check_comb();
    @(posedge clk);
    if (rst_ni) edges++;
    mdl_rdy = rst_ni && (edges >= 2) && !fifo_full_i;
    @(negedge clk);
    chk("R5 in_ready", in_ready_o, mdl_rdy);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; edges = 0; mdl_rdy = 0;
    #1 chk("R4 ready in reset", in_ready_o, 1'b0);
    @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #1 chk("R4 reset state", in_ready_o, 1'b0);
    chk("R2 reset hiz", bus_oe_o, 1'b0);
    @(negedge clk); rst_ni = 1;
    // R4: write attempt during startup is blocked, ready rises on edge 2
    cs_ni = 0; en_i = 1; wr_dir_i = 1; mbox_sel_i = 0; fifo_full_i = 0;
    step(); chk("R4 low after edge 1", in_ready_o, 1'b0);
    step(); chk("R4 high after edge 2", in_ready_o, 1'b1);
    step();
    // R5: full drops ready, recovery
    fifo_full_i = 1; step(); chk("R5 full drops", in_ready_o, 1'b0);
    step();
    fifo_full_i = 0; step(); chk("R5 recovers", in_ready_o, 1'b1);
    // R8: read from empty and non-empty FIFO
    wr_dir_i = 0; fifo_empty_i = 1; step();
    fifo_empty_i = 0; step();
    // R6/R9: mailbox both directions
    mbox_sel_i = 1; wr_dir_i = 1; step();
    wr_dir_i = 0; step();
    // R1/R2: deselected
    cs_ni = 1; step();
    cs_ni = 0; en_i = 0; step();
    // mid-run reset with full asserted
    fifo_full_i = 1; do_reset();
    fifo_full_i = 0; step(); chk("R4 low edge 1 after rerun", in_ready_o, 1'b0);
    step();
    // random mix
    for (int i = 0; i < 400; i++) begin
      cs_ni        = ($urandom % 4) == 0;
      en_i         = ($urandom % 4) != 0;
      mbox_sel_i   = $urandom % 2;
      wr_dir_i     = $urandom % 2;
      fifo_full_i  = ($urandom % 5) == 0;
      fifo_empty_i = ($urandom % 4) == 0;
      if (($urandom % 97) == 0) do_reset();
      step();
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule